// File: doc/BRIEF.md
# Global-History Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a short shift register of the most recent resolved branch outcomes. That pattern picks one of several banks of saturating counters. A slice of the branch address then picks a counter within the bank, and the counter's upper half means "taken". Because the bank follows the recent global path, branches whose behaviour depends on earlier branches can be told apart. A plain per-address counter table cannot do this.

The fetch stage presents a branch address on the lookup port and reads the direction back in the same cycle, with no register in the path. When the branch resolves, the back end presents its address and real outcome on the update port. The counter chosen by the current history and that address is moved one step toward the outcome. The outcome then enters the history. There is no tag check, so addresses that share the index bits share counters. Target prediction is not part of the block.

Top module: `corr_bpred`

## Requirements
- R1: After reset every counter holds the weakly-not-taken value (2^(CTR_BITS-1)-1, which is 1 for 2-bit counters) and the history is all zeros, so every lookup predicts not-taken.
- R2: `lk_taken` is 1 exactly when the counter selected by bank = current history value and row = `lk_pc[ROW_LSB +: IDX_BITS]` (default `lk_pc[6:2]`) is at or above 2^(CTR_BITS-1).
- R3: A taken update adds one to the selected counter and leaves it unchanged at the maximum 2^CTR_BITS-1.
- R4: A not-taken update subtracts one from the selected counter and leaves it unchanged at zero.
- R5: Each update shifts its outcome into history bit 0 and moves every older bit up one place; the oldest bit drops out. Bit value 1 means taken.
- R6: An update trains the counter in the bank named by the history as it stands before that update's outcome is shifted in.
- R7: A lookup in the same cycle as an update returns the prediction from the state before that update.
- R8: PC bits outside the row field have no effect: two addresses that agree in the row field read and train the same counter.
- R9: While `up_valid` is 0, `up_pc` and `up_taken` change neither the counters nor the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_taken | output | 1 | Predicted direction, 1 = taken, combinational from lk_pc |
| up_valid | input | 1 | Update strobe for a resolved branch |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench builds the block with its default values: 2 history bits, 2-bit counters, 5 index bits starting at PC bit 2, and a 32-bit PC. These are small enough that all 128 counters are reached, and the 4 history patterns are covered within a few updates each. Both saturation ends are reached after three steps in a bank. The bench also varies the PC bits above the index field freely, which exercises aliasing. A behavioural model built from integer arrays predicts `lk_taken` on every cycle. The stimulus includes directed runs (repeated taken, repeated not-taken, strict alternation, updates with the strobe low) and then a long random mix.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // reset value of an n-bit counter: one step below the taken threshold
  function automatic int unsigned weak_nt(input int unsigned nbits);
    return (1 << (nbits - 1)) - 1;
  endfunction

  // saturating move of a counter toward the resolved outcome
  function automatic int unsigned ctr_step(input int unsigned cur,
                                           input int unsigned maxv,
                                           input logic taken);
    if (taken) return (cur >= maxv) ? maxv : cur + 1;
    return (cur == 0) ? 0 : cur - 1;
  endfunction

  // taken when the counter sits in the upper half of its range
  function automatic logic is_taken(input int unsigned cur, input int unsigned nbits);
    return cur >= (1 << (nbits - 1));
  endfunction

endpackage

// File: rtl/bp_history.sv
module bp_history #(
  parameter int HIST_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic                 bit_in,
  output logic [HIST_BITS-1:0] hist
);
  logic [HIST_BITS-1:0] hist_q;

  generate
    if (HIST_BITS == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hist_q <= '0;
        else if (shift_en) hist_q <= bit_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[HIST_BITS-2:0], bit_in};
      end
    end
  endgenerate

  assign hist = hist_q;
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
  parameter int HIST_BITS = 2,
  parameter int IDX_BITS  = 5,
  parameter int CTR_BITS  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [HIST_BITS-1:0] bank,
  input  logic [IDX_BITS-1:0]  lk_row,
  input  logic [IDX_BITS-1:0]  up_row,
  input  logic                 we,
  input  logic [CTR_BITS-1:0]  wdata,
  output logic [CTR_BITS-1:0]  lk_ctr,
  output logic [CTR_BITS-1:0]  up_ctr
);
  localparam int NBANK = 1 << HIST_BITS;
  localparam int ROWS  = 1 << IDX_BITS;
  localparam logic [CTR_BITS-1:0] INIT = CTR_BITS'(bp_pkg::weak_nt(CTR_BITS));

  logic [CTR_BITS-1:0] lk_b [NBANK];
  logic [CTR_BITS-1:0] up_b [NBANK];

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic [CTR_BITS-1:0] mem [ROWS];
      logic bank_we;
      assign bank_we = we && (bank == HIST_BITS'(b));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int r = 0; r < ROWS; r++) mem[r] <= INIT;
        end else if (bank_we) begin
          mem[up_row] <= wdata;
        end
      end

      assign lk_b[b] = mem[lk_row];
      assign up_b[b] = mem[up_row];
    end
  endgenerate

  assign lk_ctr = lk_b[bank];
  assign up_ctr = up_b[bank];
endmodule

// File: rtl/corr_bpred.sv
module corr_bpred #(
  parameter int PC_W      = 32,
  parameter int HIST_BITS = 2,
  parameter int CTR_BITS  = 2,
  parameter int IDX_BITS  = 5,
  parameter int ROW_LSB   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);
  localparam int unsigned CTR_MAX = (1 << CTR_BITS) - 1;

  // named internal events, used by the bound checker
  logic [HIST_BITS-1:0] hist;
  logic [IDX_BITS-1:0]  lk_row, up_row;
  logic [CTR_BITS-1:0]  lk_ctr, wr_old, wr_new;
  logic                 upd_fire;
  logic                 unused_pc_bits;

  assign lk_row   = lk_pc[ROW_LSB +: IDX_BITS];
  assign up_row   = up_pc[ROW_LSB +: IDX_BITS];
  assign upd_fire = up_valid;
  assign unused_pc_bits = ^{lk_pc, up_pc};

  bp_history #(.HIST_BITS(HIST_BITS)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(upd_fire), .bit_in(up_taken), .hist(hist)
  );

  bp_ctr_table #(.HIST_BITS(HIST_BITS), .IDX_BITS(IDX_BITS), .CTR_BITS(CTR_BITS)) u_tab (
    .clk(clk), .rst_n(rst_n), .bank(hist), .lk_row(lk_row), .up_row(up_row),
    .we(upd_fire), .wdata(wr_new), .lk_ctr(lk_ctr), .up_ctr(wr_old)
  );

  assign wr_new   = CTR_BITS'(bp_pkg::ctr_step(int'(wr_old), CTR_MAX, up_taken));
  assign lk_taken = bp_pkg::is_taken(int'(lk_ctr), CTR_BITS);
endmodule

// File: rtl/corr_bpred_chk.sv
module corr_bpred_chk #(
  parameter int HIST_BITS = 2,
  parameter int CTR_BITS  = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 up_valid,
  input logic                 up_taken,
  input logic                 upd_fire,
  input logic [HIST_BITS-1:0] hist,
  input logic [CTR_BITS-1:0]  wr_old,
  input logic [CTR_BITS-1:0]  wr_new,
  input logic                 lk_taken,
  input logic [31:0]          lk_pc_lo
);
  localparam logic [CTR_BITS-1:0] CMAX = '1;

  // R5: newest history bit is the outcome just reported
  a_r5_hist_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> hist[0] == $past(up_taken));

  // R9: history holds when no update is presented
  a_r9_idle_hist: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(hist));

  // R3: taken at the top stays at the top
  a_r3_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && up_taken && wr_old == CMAX) |-> wr_new == CMAX);

  // R4: not-taken at zero stays at zero
  a_r4_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && !up_taken && wr_old == '0) |-> wr_new == '0);

  // R3: below the top a taken update moves exactly one step up
  a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && up_taken && wr_old != CMAX) |-> wr_new == wr_old + 1'b1);

  // R9: with no update and an unchanged address the prediction holds
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid ##1 $stable(lk_pc_lo) |-> $stable(lk_taken));
endmodule

bind corr_bpred corr_bpred_chk #(.HIST_BITS(HIST_BITS), .CTR_BITS(CTR_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_taken(up_taken),
  .upd_fire(upd_fire), .hist(hist), .wr_old(wr_old), .wr_new(wr_new),
  .lk_taken(lk_taken), .lk_pc_lo(32'(lk_pc))
);

// File: tb/corr_bpred_test.sv
`timescale 1ns/1ps
module corr_bpred_test;
  localparam int HB = 2, CB = 2, IB = 5, LSB = 2;
  localparam int ROWS = 32, NB = 4, CMAXV = 3, THR = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic [31:0] lk_pc = 0, up_pc = 0;
  logic up_valid = 0, up_taken = 0;
  logic lk_taken;

  int compared = 0, mismatched = 0;
  int ctrm [NB*ROWS];
  int hist_m = 0;

  always #10 clk = ~clk;

  corr_bpred uut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
  );

  function automatic int row_of(input logic [31:0] pc);
    return int'((pc / 4) % ROWS);
  endfunction

  function automatic int model_pred(input logic [31:0] pc);
    return (ctrm[hist_m*ROWS + row_of(pc)] >= THR) ? 1 : 0;
  endfunction

  task automatic model_update();
    int k;
    if (!up_valid) return;
    k = hist_m*ROWS + row_of(up_pc);
    if (up_taken) begin if (ctrm[k] < CMAXV) ctrm[k]++; end
    else          begin if (ctrm[k] > 0)     ctrm[k]--; end
    hist_m = ((hist_m * 2) + (up_taken ? 1 : 0)) % NB;
  endtask

  task automatic check(input string tag, input int exp);
    compared++;
    if (int'(lk_taken) != exp) begin
      mismatched++;
      $display("FAIL %s pc=%h actual=%0d expected=%0d", tag, lk_pc, lk_taken, exp);
    end
  endtask

  // one cycle: drive after the falling edge, compare, then advance the model at the rising edge
  task automatic step(input string tag, input logic [31:0] lpc, input logic v,
                      input logic [31:0] upc, input logic t);
    @(negedge clk);
    lk_pc = lpc; up_valid = v; up_pc = upc; up_taken = t;
    #5;
    check(tag, model_pred(lpc));
    @(posedge clk);
    model_update();
  endtask

  initial begin : watchdog
    #3000000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    logic [31:0] pa, pb, pc;
    for (int i = 0; i < NB*ROWS; i++) ctrm[i] = 1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;

    // R1: every counter weakly not-taken, history zero -> not-taken everywhere
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); lk_pc = 32'(i * 36 + 4); up_valid = 0;
      #5; compared++;
      if (lk_taken !== 1'b0) begin
        mismatched++;
        $display("FAIL R1 pc=%h actual=%0d expected=0", lk_pc, lk_taken);
      end
    end

    // R3: repeated taken on one branch drives its counters to the top
    pa = 32'h0000_0040;
    for (int i = 0; i < 10; i++) step("R3", pa, 1, pa, 1);
    // R4: repeated not-taken drives them to zero
    for (int i = 0; i < 10; i++) step("R4", pa, 1, pa, 0);

    // R5 R6: strict alternation is learned per history pattern
    pb = 32'h0000_0104;
    for (int i = 0; i < 24; i++) step("R6", pb, 1, pb, 1'(i % 2));
    for (int i = 0; i < 6; i++)  step("R5", pb, 0, pb, 0);

    // R7: lookup and update of the same counter in the same cycle
    for (int i = 0; i < 40; i++) begin
      pc = {$urandom} & 32'h0000_007c;
      step("R7", pc, 1, pc, 1'($urandom));
    end

    // R8: high PC bits differ, index field equal
    for (int i = 0; i < 30; i++) begin
      pc = ($urandom & 32'hffff_ff80) | 32'h0000_0018;
      step("R8", pc ^ 32'h5a5a_0000, 1, pc, 1'(i % 3 != 0));
    end

    // R9: strobe low, other update inputs toggling
    for (int i = 0; i < 20; i++) step("R9", 32'h0000_0018, 0, $urandom, 1'($urandom));

    // R2: long random mix over a few hot rows plus noise
    for (int i = 0; i < 3000; i++) begin
      pc = ($urandom % 4 == 0) ? $urandom : ($urandom & 32'hffff_000c);
      step("R2", ($urandom % 2 == 0) ? pc : $urandom, 1'($urandom % 4 != 0),
           pc, 1'($urandom % 3 != 0));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule